// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit with 56-bit Accumulator

This block is the multiply-accumulate datapath of a 32-bit processor core. Each cycle it may take two 32-bit register operands and a 4-bit operation code. The code picks which operand halves are multiplied: upper×upper, lower×lower, full word×upper, or full word×lower. It also picks whether the signed product overwrites a 56-bit accumulator or is added to it. Every multiply completes in a single clock.

Further codes handle the accumulator's contents. Two codes round it to a 16-bit or 32-bit result, return that result and leave the rounded value in the accumulator. Another code returns a left-shifted and saturated 32-bit window. Two codes return the raw upper or lower part. The remaining codes load the upper or lower part from an operand, or clear the whole accumulator. Read results are registered and appear one cycle after the request, with a one-cycle valid pulse.

Top module: `mac56_unit`

## Requirements
- R1: A synchronous active-high reset leaves the accumulator at zero, `rd_data` at zero and `rd_valid` low after the next rising edge.
- R2: Codes 0..3 (0 = upper×upper, 1 = lower×lower, 2 = word×upper, 3 = word×lower) replace the accumulator with the signed product in one cycle. Halves are bits [31:16] and [15:0] of each operand. Half×half products are shifted left by 16. All products are sign-extended to 56 bits.
- R3: Codes 4..7 use the same pairings in the same order as R2, but add the product to the accumulator, wrapping modulo 2^56.
- R4: Code 8 adds bit 31 to bits [55:32] (round half up) and returns the sum clamped to the signed 16-bit range (0x00007FFF or 0xFFFF8000), sign-extended to 32 bits. The unclamped sum is written back to bits [55:32], and bits [31:0] are cleared.
- R5: Code 9 adds bit 15 to bits [55:16] and returns the sum clamped to the signed 32-bit range (0x7FFFFFFF or 0x80000000). The unclamped sum is written back to bits [55:16], and bits [15:0] are cleared.
- R6: Code 10 shifts the sign-extended accumulator left by `shamt` (0, 1 or 2; a value of 3 acts as 2) and returns bits [47:16] of the shifted value, clamped to the signed 32-bit range. The accumulator is unchanged.
- R7: Code 11 returns accumulator bits [55:24]. Code 12 returns bits [23:0] with bit 23 copied into bits [31:24]. Neither code changes the accumulator.
- R8: Code 13 loads `src_a` into accumulator bits [55:24]. Code 14 loads `src_a[23:0]` into bits [23:0]. The other bits are kept in both cases.
- R9: Code 15 sets all 56 accumulator bits to zero on the next edge.
- R10: Only codes 8..12 with `op_valid` high update `rd_data`, and they raise `rd_valid` for exactly one cycle after the request edge. When `op_valid` is low, neither the accumulator nor `rd_data` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies the operation code this cycle |
| op_code | input | 4 | Operation select, encodings per R2 to R9 |
| src_a | input | 32 | First operand, and load data for codes 13 and 14 |
| src_b | input | 32 | Second operand |
| shamt | input | 2 | Left shift amount for code 10 |
| rd_data | output | 32 | Registered read result |
| rd_valid | output | 1 | High for one cycle when `rd_data` carries a new result |

## Verification
Products are tried with mixed-sign halves, the most negative word times the most negative halfword, and an accumulate on top of a prior product. Together these separate the four pairings, the 16-bit alignment of half×half products, and overwrite versus add. Rounding is tried exactly at, just under and below the half-LSB point, including a negative half case. This shows round half up rather than round away from zero. Each rounding and shift width is also pushed past its positive and negative limits, to tell saturated results from wrapped ones. A wrap across 2^55 and an idle cycle carrying the clear code check that accumulation wraps and that unqualified codes are ignored.

// File: rtl/mac56_unit.sv
module mac56_unit (
  input  logic        clk,
  input  logic        rst,
  input  logic        op_valid,
  input  logic [3:0]  op_code,
  input  logic [31:0] src_a,
  input  logic [31:0] src_b,
  input  logic [1:0]  shamt,
  output logic [31:0] rd_data,
  output logic        rd_valid
);
  localparam logic [3:0] OP_RND16 = 4'd8;
  localparam logic [3:0] OP_RND32 = 4'd9;
  localparam logic [3:0] OP_SHRD  = 4'd10;
  localparam logic [3:0] OP_RDHI  = 4'd11;
  localparam logic [3:0] OP_RDLO  = 4'd12;
  localparam logic [3:0] OP_WRHI  = 4'd13;
  localparam logic [3:0] OP_WRLO  = 4'd14;
  localparam logic [3:0] OP_CLR   = 4'd15;

  logic [55:0] acc, acc_nx;
  logic [31:0] rd_nx;

  // operand half selection: op_code[0] picks low halves, op_code[1] picks full word for A
  logic [15:0] a_half, b_half;
  logic [31:0] p_half;
  logic [47:0] p_wide;
  logic [55:0] prod;

  assign a_half = op_code[0] ? src_a[15:0] : src_a[31:16];
  assign b_half = op_code[0] ? src_b[15:0] : src_b[31:16];
  assign p_half = {{16{a_half[15]}}, a_half} * {{16{b_half[15]}}, b_half};
  assign p_wide = {{16{src_a[31]}}, src_a} * {{32{b_half[15]}}, b_half};
  assign prod   = op_code[1] ? {{8{p_wide[47]}}, p_wide}
                             : {{8{p_half[31]}}, p_half, 16'b0};

  // rounding: adding the half-LSB then truncating equals adding the bit below the cut
  logic [23:0] r16;
  logic [39:0] r32;
  logic [31:0] rd16, rd32;

  assign r16  = acc[55:32] + {23'b0, acc[31]};
  assign r32  = acc[55:16] + {39'b0, acc[15]};
  assign rd16 = (r16[23:15] == {9{r16[23]}}) ? {{16{r16[15]}}, r16[15:0]}
              : (r16[23] ? 32'hFFFF_8000 : 32'h0000_7FFF);
  assign rd32 = (r32[39:31] == {9{r32[39]}}) ? r32[31:0]
              : (r32[39] ? 32'h8000_0000 : 32'h7FFF_FFFF);

  // shifted readout window: bits [57:16] of the sign-extended accumulator << shamt
  logic [41:0] sh_win;
  logic [31:0] rd_sh;

  always_comb begin
    case (shamt)
      2'd0:    sh_win = {{2{acc[55]}}, acc[55:16]};
      2'd1:    sh_win = {acc[55], acc[55:15]};
      default: sh_win = acc[55:14];
    endcase
  end
  assign rd_sh = (sh_win[41:31] == {11{sh_win[41]}}) ? sh_win[31:0]
               : (sh_win[41] ? 32'h8000_0000 : 32'h7FFF_FFFF);

  logic is_read;
  assign is_read = (op_code >= OP_RND16) && (op_code <= OP_RDLO);

  always_comb begin
    acc_nx = acc;
    rd_nx  = rd_data;
    if (!op_code[3]) begin
      acc_nx = op_code[2] ? acc + prod : prod;
    end else begin
      case (op_code)
        OP_RND16: begin acc_nx = {r16, 32'b0}; rd_nx = rd16; end
        OP_RND32: begin acc_nx = {r32, 16'b0}; rd_nx = rd32; end
        OP_SHRD:  rd_nx  = rd_sh;
        OP_RDHI:  rd_nx  = acc[55:24];
        OP_RDLO:  rd_nx  = {{8{acc[23]}}, acc[23:0]};
        OP_WRHI:  acc_nx = {src_a, acc[23:0]};
        OP_WRLO:  acc_nx = {acc[55:24], src_a[23:0]};
        OP_CLR:   acc_nx = '0;
        default:  acc_nx = acc;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= op_valid && is_read;
      if (op_valid) begin
        acc     <= acc_nx;
        rd_data <= rd_nx;
      end
    end
  end

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (acc == '0 && rd_data == '0 && !rd_valid)); // R1
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CLR) |=> (acc == '0)); // R9
  AST_READ_PULSE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && is_read) |=> rd_valid); // R10
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
    !(op_valid && is_read) |=> !rd_valid); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc) && $stable(rd_data))); // R10
  AST_READ_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= OP_SHRD && op_code <= OP_RDLO) |=> $stable(acc)); // R7
  AST_RND16_RANGE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_RND16) |=> (rd_data[31:15] == {17{rd_data[31]}})); // R4
endmodule

// File: tb/mac56_unit_test.sv
module mac56_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [1:0]  shamt = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int tests = 0;
  int fails = 0;
  logic done = 1'b0;
  logic [55:0] m_acc = '0;

  always #2 clk = ~clk;

  mac56_unit uut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .shamt(shamt),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] sh);
    @(negedge clk);
    op_valid = 1'b1; op_code = op; src_a = a; src_b = b; shamt = sh;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic load(input logic [55:0] v);
    issue(4'd13, v[55:24], 32'h0, 2'd0);
    issue(4'd14, {8'h0, v[23:0]}, 32'h0, 2'd0);
    m_acc = v;
  endtask

  task automatic read_acc(input string req);
    issue(4'd11, 32'h0, 32'h0, 2'd0);
    chk(req, {32'h0, rd_data}, {32'h0, m_acc[55:24]});
    issue(4'd12, 32'h0, 32'h0, 2'd0);
    chk(req, {32'h0, rd_data}, {32'h0, {{8{m_acc[23]}}, m_acc[23:0]}});
  endtask

  function automatic logic [55:0] mprod(input int sel, input logic [31:0] a, input logic [31:0] b);
    longint p;
    case (sel)
      0: p = longint'($signed(a[31:16])) * longint'($signed(b[31:16])) * 65536;
      1: p = longint'($signed(a[15:0])) * longint'($signed(b[15:0])) * 65536;
      2: p = longint'($signed(a)) * longint'($signed(b[31:16]));
      default: p = longint'($signed(a)) * longint'($signed(b[15:0]));
    endcase
    return p[55:0];
  endfunction

  task automatic t_reset;
    chk("R1 rd_data", {32'h0, rd_data}, 64'h0);
    chk("R1 rd_valid", {63'h0, rd_valid}, 64'h0);
    read_acc("R1 acc");
  endtask

  task automatic t_mul;
    logic [31:0] a, b;
    a = 32'hFFFE_1234; b = 32'h0003_5678;
    for (int s = 0; s < 4; s++) begin
      issue(4'(s), a, b, 2'd0);
      m_acc = mprod(s, a, b);
      read_acc("R2 mul pairing");
    end
    issue(4'd0, a, b, 2'd0);
    m_acc = 56'hFF_FFFF_FFFA_0000;
    read_acc("R2 hh aligned");
    issue(4'd3, 32'h8000_0000, 32'h0000_8000, 2'd0);
    m_acc = 56'h00_4000_0000_0000;
    read_acc("R2 min word x min half");
  endtask

  task automatic t_mac;
    logic [31:0] a, b;
    a = 32'h8001_FF00; b = 32'h7FFF_0FF1;
    issue(4'd2, a, b, 2'd0);
    m_acc = mprod(2, a, b);
    for (int s = 0; s < 4; s++) begin
      issue(4'(4 + s), a, b, 2'd0);
      m_acc = m_acc + mprod(s, a, b);
      read_acc("R3 mac pairing");
    end
    load(56'h7F_FFFF_FFFF_0000);
    issue(4'd5, 32'h1, 32'h1, 2'd0);
    m_acc = 56'h80_0000_0000_0000;
    read_acc("R3 wrap");
  endtask

  task automatic rnd(input string req, input logic [3:0] op, input logic [55:0] v,
                     input logic [31:0] exp_rd, input logic [55:0] exp_acc);
    load(v);
    issue(op, 32'h0, 32'h0, 2'd0);
    chk(req, {32'h0, rd_data}, {32'h0, exp_rd});
    m_acc = exp_acc;
    read_acc(req);
  endtask

  task automatic t_rnd16;
    rnd("R4 half up", 4'd8, 56'h00_0001_8000_0000, 32'h0000_0002, 56'h00_0002_0000_0000);
    rnd("R4 below half", 4'd8, 56'h00_0001_7FFF_FFFF, 32'h0000_0001, 56'h00_0001_0000_0000);
    rnd("R4 neg half", 4'd8, 56'hFF_FFFE_8000_0000, 32'hFFFF_FFFF, 56'hFF_FFFF_0000_0000);
    rnd("R4 sat pos", 4'd8, 56'h00_8000_0000_0000, 32'h0000_7FFF, 56'h00_8000_0000_0000);
    rnd("R4 sat neg", 4'd8, 56'hFF_0000_0000_0000, 32'hFFFF_8000, 56'hFF_0000_0000_0000);
  endtask

  task automatic t_rnd32;
    rnd("R5 half up", 4'd9, 56'h00_0000_1234_8000, 32'h0000_1235, 56'h00_0000_1235_0000);
    rnd("R5 below half", 4'd9, 56'h00_0000_1234_7FFF, 32'h0000_1234, 56'h00_0000_1234_0000);
    rnd("R5 sat pos", 4'd9, 56'h01_0000_0000_0000, 32'h7FFF_FFFF, 56'h01_0000_0000_0000);
    rnd("R5 sat neg", 4'd9, 56'hFE_0000_0000_0000, 32'h8000_0000, 56'hFE_0000_0000_0000);
  endtask

  task automatic shrd(input string req, input logic [55:0] v, input logic [1:0] sh,
                      input logic [31:0] exp_rd);
    load(v);
    issue(4'd10, 32'h0, 32'h0, sh);
    chk(req, {32'h0, rd_data}, {32'h0, exp_rd});
  endtask

  task automatic t_shift;
    shrd("R6 sh0", 56'h00_0000_4000_C000, 2'd0, 32'h0000_4000);
    shrd("R6 sh1", 56'h00_0000_4000_C000, 2'd1, 32'h0000_8001);
    shrd("R6 sh2", 56'h00_0000_4000_C000, 2'd2, 32'h0001_0003);
    read_acc("R6 acc kept");
    shrd("R6 sh0 big", 56'h00_4000_0000_0000, 2'd0, 32'h4000_0000);
    shrd("R6 sat pos", 56'h00_4000_0000_0000, 2'd1, 32'h7FFF_FFFF);
    shrd("R6 neg fits", 56'hFF_C000_0000_0000, 2'd1, 32'h8000_0000);
    shrd("R6 sat neg", 56'hFF_BFFF_0000_0000, 2'd2, 32'h8000_0000);
    shrd("R6 sat neg sh3", 56'hFF_9FFF_0000_0000, 2'd3, 32'h8000_0000);
  endtask

  task automatic t_raw_write;
    load(56'h12_3456_789A_BCDE);
    issue(4'd11, 32'h0, 32'h0, 2'd0);
    chk("R7 raw hi", {32'h0, rd_data}, 64'h1234_5678);
    issue(4'd12, 32'h0, 32'h0, 2'd0);
    chk("R7 raw lo sign pad", {32'h0, rd_data}, 64'hFF9A_BCDE);
    issue(4'd13, 32'hCAFE_F00D, 32'h0, 2'd0);
    m_acc = 56'hCA_FEF0_0D9A_BCDE;
    read_acc("R8 write hi keeps lo");
    issue(4'd14, 32'hFF01_2345, 32'h0, 2'd0);
    m_acc = 56'hCA_FEF0_0D01_2345;
    read_acc("R8 write lo keeps hi");
  endtask

  task automatic t_idle_valid;
    load(56'h00_1111_2222_3333);
    @(negedge clk);
    op_code = 4'd15; src_a = 32'hFFFF_FFFF;
    @(negedge clk);
    chk("R10 idle no valid", {63'h0, rd_valid}, 64'h0);
    read_acc("R10 idle ignores clear");
    issue(4'd11, 32'h0, 32'h0, 2'd0);
    chk("R10 valid pulse", {63'h0, rd_valid}, 64'h1);
    @(negedge clk);
    chk("R10 valid one cycle", {63'h0, rd_valid}, 64'h0);
    issue(4'd0, 32'h0001_0000, 32'h0001_0000, 2'd0);
    chk("R10 mul no valid", {63'h0, rd_valid}, 64'h0);
    chk("R10 rd_data held", {32'h0, rd_data}, 64'h0011_1122);
  endtask

  task automatic t_clear;
    load(56'hA5_A5A5_A5A5_A5A5);
    issue(4'd15, 32'h0, 32'h0, 2'd0);
    m_acc = '0;
    read_acc("R9 clear");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_reset();
    t_mul();
    t_mac();
    t_rnd16();
    t_rnd32();
    t_shift();
    t_raw_write();
    t_idle_valid();
    t_clear();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule